// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division for an integer core and keeps the results in two architectural result registers, HI and LO. A request is a one-cycle `start` pulse that carries an operation code and two operands. Multiplication uses a single-cycle array and loads both registers at the start edge. Division runs a restoring divider that produces one quotient bit per clock. It holds `busy` for the whole run, then gives one cycle with `done` high and `busy` low, in which the new HI and LO values are first visible.

Divide-by-zero and the single signed overflow case never trap. Each gives a fixed HI/LO pair. Software can also load HI or LO directly while the unit is idle. A consumer that reads HI or LO waits while `busy` is high. Both registers hold their old values for the whole division, so an early read can never see a partial result.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `hi` and `lo` are 0 and `busy` and `done` are low.
- R2: Operation code 0 is a signed multiply. Both operands are sign-extended to 64 bits. The product's low 32 bits go to `lo` and its high 32 bits go to `hi`.
- R3: Operation code 1 is an unsigned multiply. Both operands are zero-extended, and the product is split as in R2.
- R4: A multiply never raises `busy`. Its result and a one-cycle `done` pulse are visible in the cycle after the clock edge that samples `start`.
- R5: Operation code 2 is a signed divide. `lo` gets the quotient, truncated toward zero. `hi` gets the remainder, which carries the sign of the dividend.
- R6: Operation code 3 is an unsigned divide. `lo` gets the quotient and `hi` gets the remainder.
- R7: A signed divide by zero sets `hi` to the dividend. `lo` becomes 0xFFFFFFFF for a non-negative dividend and 0x00000001 for a negative one.
- R8: An unsigned divide by zero sets `lo` to 0xFFFFFFFF and `hi` to the dividend.
- R9: A signed divide of 0x80000000 by 0xFFFFFFFF sets `lo` to 0x80000000 and `hi` to 0.
- R10: A divide holds `busy` high for exactly 32 cycles after the clock edge that samples `start`. In the next cycle, `busy` is low, `done` is high for one cycle, and the results are visible.
- R11: While `busy` is high, `hi` and `lo` keep their previous values.
- R12: A `start` sampled while a divide is running abandons that divide. The unit begins the new operation, and the latency of R4 or R10 is counted from the new start.
- R13: While the unit is idle and no `start` is present, `wr_hi` loads `wr_data` into `hi` only and `wr_lo` loads it into `lo` only. Both may be given in the same cycle.
- R14: A direct write given while `busy` is high, or in the same cycle as `start`, has no effect on `hi` or `lo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 2 | 0 signed mul, 1 unsigned mul, 2 signed div, 3 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| wr_hi | input | 1 | Direct load of HI from `wr_data` |
| wr_lo | input | 1 | Direct load of LO from `wr_data` |
| wr_data | input | 32 | Data for direct loads |
| hi | output | 32 | HI register (high product or remainder) |
| lo | output | 32 | LO register (low product or quotient) |
| busy | output | 1 | Divide in progress; readers of HI/LO wait |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The hardest case to reach is a restart in the middle of a divide. The divider state is then half-shifted, and the new operation has to throw it away completely. The bench starts one divide, lets it run for a chosen number of steps, and then issues a second `start` with different operands. In one run the second operation is a divide and in another it is a multiply. The bench checks that the latency counts from the second strobe and that only the second operation's result appears. Direct writes are also issued while the unit is busy and in the same cycle as a start, to show that they never land.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'd0,
        OP_MULU = 2'd1,
        OP_DIVS = 2'd2,
        OP_DIVU = 2'd3
    } md_op_e;

endpackage

// File: rtl/md_mul_array.sv
// Single-cycle widening multiplier with a signed/unsigned operand extension.
module md_mul_array #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           is_signed,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] ext_a;
    logic [2*W-1:0] ext_b;

    always_comb begin
        ext_a = {{W{is_signed & a[W-1]}}, a};
        ext_b = {{W{is_signed & b[W-1]}}, b};
        prod  = ext_a * ext_b;
    end
endmodule

// File: rtl/md_div_step.sv
// One restoring-division iteration on magnitudes: shift, trial subtract, keep or restore.
module md_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] shifted;
    logic [W:0] trial;

    always_comb begin
        shifted = {rem_in, quo_in[W-1]};
        trial   = shifted - {1'b0, dvs};
        if (!trial[W]) begin
            rem_out = trial[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b1};
        end else begin
            rem_out = shifted[W-1:0];
            quo_out = {quo_in[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/md_div_fixup.sv
// Applies signs to the magnitude results and substitutes the fixed divide-by-zero values.
// The signed overflow case needs no special path: the magnitude quotient 2^(W-1),
// negated, is again 2^(W-1), and the remainder is zero.
module md_div_fixup #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_mag,
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] dividend,
    input  logic         is_signed,
    input  logic         neg_quo,
    input  logic         neg_rem,
    input  logic         by_zero,
    output logic [W-1:0] hi_res,
    output logic [W-1:0] lo_res
);
    always_comb begin
        if (by_zero) begin
            hi_res = dividend;
            lo_res = (is_signed && dividend[W-1]) ? W'(1) : '1;
        end else begin
            hi_res = neg_rem ? -rem_mag : rem_mag;
            lo_res = neg_quo ? -quo_mag : quo_mag;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo,
    output logic         busy,
    output logic         done
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     hi;
        logic [W-1:0]     lo;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
        logic [W-1:0]     dividend;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
        logic             sgn;
        logic             neg_quo;
        logic             neg_rem;
        logic             by_zero;
    } md_state_t;

    md_state_t st_d, st_q;

    logic [2*W-1:0] prod;
    logic [W-1:0]   step_rem, step_quo;
    logic [W-1:0]   fix_hi, fix_lo;
    logic           op_is_div, op_signed;

    assign op_is_div = op[1];
    assign op_signed = (op == OP_MULS) || (op == OP_DIVS);

    md_mul_array #(.W(W)) u_mul (
        .a         (src_a),
        .b         (src_b),
        .is_signed (op_signed),
        .prod      (prod)
    );

    md_div_step #(.W(W)) u_step (
        .rem_in  (st_q.rem),
        .quo_in  (st_q.quo),
        .dvs     (st_q.dvs),
        .rem_out (step_rem),
        .quo_out (step_quo)
    );

    md_div_fixup #(.W(W)) u_fix (
        .rem_mag   (step_rem),
        .quo_mag   (step_quo),
        .dividend  (st_q.dividend),
        .is_signed (st_q.sgn),
        .neg_quo   (st_q.neg_quo),
        .neg_rem   (st_q.neg_rem),
        .by_zero   (st_q.by_zero),
        .hi_res    (fix_hi),
        .lo_res    (fix_lo)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            if (!op_is_div) begin
                st_d.hi   = prod[2*W-1:W];
                st_d.lo   = prod[W-1:0];
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.sgn      = op_signed;
                st_d.dividend = src_a;
                st_d.quo      = (op_signed && src_a[W-1]) ? -src_a : src_a;
                st_d.dvs      = (op_signed && src_b[W-1]) ? -src_b : src_b;
                st_d.rem      = '0;
                st_d.neg_quo  = op_signed && (src_a[W-1] ^ src_b[W-1]);
                st_d.neg_rem  = op_signed && src_a[W-1];
                st_d.by_zero  = (src_b == '0);
                st_d.cnt      = '0;
                st_d.busy     = 1'b1;
            end
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.quo = step_quo;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_STEP) begin
                st_d.hi   = fix_hi;
                st_d.lo   = fix_lo;
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else begin
            if (wr_hi) st_d.hi = wr_data;
            if (wr_lo) st_d.lo = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi   = st_q.hi;
    assign lo   = st_q.lo;
    assign busy = st_q.busy;
    assign done = st_q.done;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         is_div,
    input logic         wr_hi,
    input logic         wr_lo,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo,
    input logic         busy,
    input logic         done
);
    logic [15:0] lat;
    logic        track;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat   <= '0;
            track <= 1'b0;
        end else if (start) begin
            lat   <= '0;
            track <= is_div;
        end else if (track) begin
            lat <= lat + 1'b1;
            if (done) track <= 1'b0;
        end
    end

    p_mul_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start && !is_div |=> done && !busy);

    p_div_enters_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start && is_div |=> busy && !done);

    p_div_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        track && done |-> lat == 16'(W));

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_hold_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(hi) && $stable(lo));

    p_direct_hi_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start && wr_hi |=> hi == $past(wr_data));

    p_direct_lo_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start && wr_lo |=> lo == $past(wr_data));

    p_busy_write_ignored_r14: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !start && wr_hi && !wr_lo |=> lo == $past(lo) || done);
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .is_div  (op[1]),
    .wr_hi   (wr_hi),
    .wr_lo   (wr_lo),
    .wr_data (wr_data),
    .hi      (hi),
    .lo      (lo),
    .busy    (busy),
    .done    (done)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] src_a = '0, src_b = '0;
    logic        wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] hi, lo;
    logic        busy, done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    muldiv_unit u_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_a(src_a), .src_b(src_b), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .hi(hi), .lo(lo), .busy(busy), .done(done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(logic [31:0] a, logic [31:0] b, logic sgn);
        longint sa, sb;
        logic [63:0] ua, ub;
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            return 64'(sa * sb);
        end
        ua = {32'b0, a};
        ub = {32'b0, b};
        return ua * ub;
    endfunction

    // returns {hi, lo}
    function automatic logic [63:0] ref_div(logic [31:0] a, logic [31:0] b, logic sgn);
        longint sa, sb, q, r;
        if (b == 0) return {a, (sgn && a[31]) ? 32'h1 : 32'hFFFF_FFFF};
        if (sgn) begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
        end
        return {a % b, a / b};
    endfunction

    task automatic issue(logic [1:0] o, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hi", hi, 32'h0);
        chk("R1", "lo", lo, 32'h0);
        chk("R1", "busy/done", {30'b0, busy, done}, 32'h0);
    endtask

    task automatic t_mul(string req, logic [31:0] a, logic [31:0] b, logic sgn);
        logic [63:0] e;
        e = ref_mul(a, b, sgn);
        issue(sgn ? 2'd0 : 2'd1, a, b);
        chk(req, "mul hi", hi, e[63:32]);
        chk(req, "mul lo", lo, e[31:0]);
        chk("R4", "mul done/busy", {30'b0, done, busy}, 32'h2);
    endtask

    // waits out a divide whose start was sampled at the previous edge
    task automatic wait_div(string req, logic [63:0] e, logic [31:0] old_hi, logic [31:0] old_lo);
        int busy_cnt = 0;
        int held = 1;
        for (int i = 0; i < 32; i++) begin
            if (busy && !done) busy_cnt++;
            if (hi !== old_hi || lo !== old_lo) held = 0;
            @(negedge clk);
        end
        chk("R10", "busy cycles", 32'(busy_cnt), 32'd32);
        chk("R11", "hi/lo held while busy", 32'(held), 32'd1);
        chk("R10", "done/busy at end", {30'b0, done, busy}, 32'h2);
        chk(req, "div hi", hi, e[63:32]);
        chk(req, "div lo", lo, e[31:0]);
        @(negedge clk);
        chk("R10", "done one cycle", {31'b0, done}, 32'h0);
    endtask

    task automatic t_div(string req, logic [31:0] a, logic [31:0] b, logic sgn);
        logic [31:0] oh, ol;
        oh = hi; ol = lo;
        issue(sgn ? 2'd2 : 2'd3, a, b);
        wait_div(req, ref_div(a, b, sgn), oh, ol);
    endtask

    task automatic t_direct_write();
        @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'h1234_5678;
        @(negedge clk);
        wr_hi = 1'b0;
        chk("R13", "hi loaded", hi, 32'h1234_5678);
        chk("R13", "lo kept", lo, ref_div(32'd100, 32'd7, 1'b0) >> 0 & 64'hFFFF_FFFF);
        wr_lo = 1'b1; wr_data = 32'hCAFE_0001;
        @(negedge clk);
        wr_lo = 1'b0;
        chk("R13", "lo loaded", lo, 32'hCAFE_0001);
        chk("R13", "hi kept", hi, 32'h1234_5678);
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'h0BAD_F00D;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R13", "both hi", hi, 32'h0BAD_F00D);
        chk("R13", "both lo", lo, 32'h0BAD_F00D);
    endtask

    task automatic t_write_ignored();
        // write in the same cycle as a divide start
        @(negedge clk);
        start = 1'b1; op = 2'd3; src_a = 32'd1000; src_b = 32'd3;
        wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        start = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R14", "hi after start+write", hi, 32'h0BAD_F00D);
        // write while busy
        repeat (5) @(negedge clk);
        wr_hi = 1'b1; wr_data = 32'h5555_AAAA;
        @(negedge clk);
        wr_hi = 1'b0;
        chk("R14", "hi after busy write", hi, 32'h0BAD_F00D);
        while (!done) @(negedge clk);
        chk("R14", "div hi not overwritten", hi, 32'd1);
        chk("R14", "div lo not overwritten", lo, 32'd333);
        @(negedge clk);
    endtask

    task automatic t_restart_div();
        logic [31:0] oh, ol;
        oh = hi; ol = lo;
        issue(2'd2, 32'hFFFF_FF00, 32'd9);
        repeat (10) @(negedge clk);
        chk("R12", "busy before restart", {31'b0, busy}, 32'h1);
        issue(2'd3, 32'hF000_0000, 32'd7);
        wait_div("R12", ref_div(32'hF000_0000, 32'd7, 1'b0), oh, ol);
    endtask

    task automatic t_restart_mul();
        logic [63:0] e;
        issue(2'd3, 32'd77, 32'd5);
        repeat (4) @(negedge clk);
        e = ref_mul(32'h8000_0001, 32'd3, 1'b1);
        issue(2'd0, 32'h8000_0001, 32'd3);
        chk("R12", "mul restart busy/done", {30'b0, busy, done}, 32'h1);
        chk("R12", "mul restart hi", hi, e[63:32]);
        chk("R12", "mul restart lo", lo, e[31:0]);
        repeat (40) @(negedge clk);
        chk("R12", "old divide never lands lo", lo, e[31:0]);
    endtask

    initial begin
        #(5ns * 100000);
        errors++;
        checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_mul("R2", 32'hFFFF_FFFE, 32'd3, 1'b1);
        t_mul("R2", 32'h8000_0000, 32'h8000_0000, 1'b1);
        t_mul("R3", 32'hFFFF_FFFE, 32'd3, 1'b0);
        t_mul("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        t_div("R5", 32'hFFFF_FFF9, 32'd2, 1'b1);
        t_div("R5", 32'd7, 32'hFFFF_FFFE, 1'b1);
        t_div("R5", 32'h8000_0000, 32'd3, 1'b1);
        t_div("R6", 32'hFFFF_FFFF, 32'd10, 1'b0);
        t_div("R6", 32'd5, 32'hFFFF_FFF0, 1'b0);
        t_div("R7", 32'd42, 32'd0, 1'b1);
        chk("R7", "lo nonneg dividend", lo, 32'hFFFF_FFFF);
        t_div("R7", 32'hFFFF_FFD6, 32'd0, 1'b1);
        chk("R7", "lo negative dividend", lo, 32'h0000_0001);
        t_div("R8", 32'h9000_0000, 32'd0, 1'b0);
        t_div("R9", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
        chk("R9", "overflow lo", lo, 32'h8000_0000);
        chk("R9", "overflow hi", hi, 32'h0);
        t_div("R6", 32'd100, 32'd7, 1'b0);
        t_direct_write();
        t_write_ignored();
        t_restart_div();
        t_restart_mul();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule